// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a ring of two-word transmit descriptors held in a word-wide memory and turns the buffers they point at into a byte stream with frame markers. Software fills in descriptors and clears their used flag. It then pulses a start command. The block fetches one descriptor at a time from its current ring position and reads the buffer named by the descriptor. It sends the buffer's bytes to a downstream sink through a valid/ready handshake. It then writes the descriptor's control word back to memory with the used flag set, so software can reclaim the buffer.

A frame may span several buffers. The last buffer carries an end-of-frame flag. The first buffer's no-CRC request travels with the stream as a sideband bit. Underrun and retry-limit conditions come from the transmit side as inputs, and the block records them in the write-back of the frame's final descriptor. A halt command lets the frame in progress finish and then stops the block. Dropping the transmit enable stops it at once and returns the ring position to the programmed base.

Top module: `tdr_tx_ring`

## Requirements
- R1: After reset, with transmit disabled, busy, out_valid, mem_rd and mem_we are all low.
- R2: A start pulse while enabled and idle raises busy on the next cycle. Busy then stays high until processing stops. The first memory read after an enable cycle is at the ring base.
- R3: A descriptor is an address word at ring position P and a control word at P+4. Control bits 10:0 hold the buffer length in bytes. Bytes go out in ascending address order from any starting alignment. Byte address A sits in bits 8*(A mod 4)+7 : 8*(A mod 4) of memory word A/4. Read data returns one cycle after mem_rd.
- R4: out_sof is high only on the first byte of a frame. out_eof is high only on the last byte of a descriptor whose control bit 15 is set. The buffers of a multi-descriptor frame are sent back to back.
- R5: During a frame, out_nocrc equals control bit 16 of the frame's first descriptor.
- R6: While out_valid is high and out_ready is low, out_data, out_sof and out_eof hold their values and out_valid stays high.
- R7: After a descriptor's bytes are sent, its control word is written back at P+4. Bit 31 (used) is set and the other bits are kept, apart from the error flags of R10 and R11.
- R8: If control bit 30 (wrap) is set, the next descriptor is fetched from the ring base. Otherwise it is fetched from P+8.
- R9: A descriptor with bit 31 set, found at the start of a frame, stops processing with no write-back. The ring position is not advanced, so the next start reads the same descriptor again.
- R10: A descriptor with bit 31 set, found partway through a frame, is written back with bit 27 also set. No out_eof is sent and processing stops.
- R11: If underrun_in is seen during a frame, the final descriptor's write-back gets bit 28 set. If retry_lim_in is seen, it gets bit 29 set.
- R12: A halt command lets the current frame finish, including its end marker and write-back. Busy then drops and no further descriptor is fetched.
- R13: The ring position is kept from one start command to the next. Low transmit enable forces idle on the next cycle and sets the position back to the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; low forces idle and rewinds to base |
| ring_base | input | AW | Byte address of the first descriptor |
| start_cmd | input | 1 | Begin processing the ring |
| halt_cmd | input | 1 | Stop after the current frame |
| busy | output | 1 | Processing in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| underrun_in | input | 1 | Underrun event from the transmit side |
| retry_lim_in | input | 1 | Retry-limit event from the transmit side |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Stream byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_nocrc | output | 1 | Frame must not get a CRC appended |

## Verification
Busy is due one cycle after the start pulse. The descriptor address read follows in the same cycle and the control read one cycle later. The first byte appears three cycles after the control word arrives. Each descriptor's write-back comes in the cycle after its last accepted byte. The bench drives and samples only on falling edges. It sets out_ready for the next rising edge before it records a transfer, so every recorded byte is one the design actually handed over. Write-back words are read back from the bench memory only after busy has dropped.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int CTL_W  = 32;
  localparam int LEN_W  = 11;
  localparam int B_LAST  = 15;
  localparam int B_NOCRC = 16;
  localparam int B_EXH   = 27;
  localparam int B_UND   = 28;
  localparam int B_RTY   = 29;
  localparam int B_WRAP  = 30;
  localparam int B_USED  = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_ADR, S_CTL, S_DEC, S_BRD, S_BLD, S_EMIT, S_WB
  } tdr_state_t;
endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
  parameter int AW         = 12,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  always_ff @(posedge clk) begin
    if (rst || !en)  ptr <= base;
    else if (adv)    ptr <= wrap ? base : ptr + STEP;
  end
endmodule

// File: rtl/tdr_byte_unpack.sv
module tdr_byte_unpack #(
  parameter int AW    = 12,
  parameter int LEN_W = 11,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_addr,
  input  logic [AW-1:0]    addr_in,
  input  logic             ld_len,
  input  logic [LEN_W-1:0] len_in,
  input  logic             ld_word,
  input  logic [DW-1:0]    word_in,
  input  logic             take,
  output logic [AW-1:0]    cur_addr,
  output logic [7:0]       byte_out,
  output logic             last_byte,
  output logic             lane_end
);
  localparam int LANES = DW / 8;
  localparam int LB    = $clog2(LANES);

  logic [DW-1:0]    wbuf;
  logic [LEN_W-1:0] rem;
  logic [7:0]       lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = wbuf[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      rem      <= '0;
      wbuf     <= '0;
    end else begin
      if (ld_addr) cur_addr <= addr_in;
      if (ld_len)  rem      <= len_in;
      if (ld_word) wbuf     <= word_in;
      if (take) begin
        cur_addr <= cur_addr + AW'(1);
        rem      <= rem - LEN_W'(1);
      end
    end
  end

  assign byte_out  = lane[cur_addr[LB-1:0]];
  assign last_byte = (rem == LEN_W'(1));
  assign lane_end  = &cur_addr[LB-1:0];

  // R3: a byte is never taken once the buffer count is exhausted
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    take |-> (rem != '0));
endmodule

// File: rtl/tdr_err_latch.sv
module tdr_err_latch #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          active,
  input  logic [NF-1:0] ev_in,
  output logic [NF-1:0] ev_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) ev_q <= '0;
    else            ev_q <= ev_q | (ev_in & {NF{active}});
  end
endmodule

// File: rtl/tdr_tx_ring.sv
module tdr_tx_ring
  import tdr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic [AW-1:0] ring_base,
  input  logic          start_cmd,
  input  logic          halt_cmd,
  output logic          busy,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          underrun_in,
  input  logic          retry_lim_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic          out_nocrc
);
  localparam int DW = 32;
  localparam int LB = $clog2(DW / 8);
  localparam logic [AW-1:0] CTL_OFS = AW'(4);

  tdr_state_t        st;
  logic              in_frame, halt_pend, nocrc_q, sof_pend, exh_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [AW-1:0]     ptr, cur_addr;
  logic [7:0]        cur_byte;
  logic              last_byte, lane_end;
  logic              take, adv, dec_used, dec_halt, frame_go, err_clr;
  logic [1:0]        err_q;

  assign dec_used = mem_rdata[B_USED];
  assign dec_halt = !in_frame && halt_pend;
  assign frame_go = (st == S_DEC) && !dec_used && !dec_halt;
  assign err_clr  = frame_go && !in_frame;
  assign take     = (st == S_EMIT) && out_ready;
  assign adv      = (st == S_WB) && !exh_q;

  tdr_ring_ptr #(.AW(AW), .DESC_BYTES(8)) u_ptr (
    .clk(clk), .rst(rst), .en(tx_en), .base(ring_base),
    .adv(adv), .wrap(ctl_q[B_WRAP]), .ptr(ptr)
  );

  tdr_byte_unpack #(.AW(AW), .LEN_W(LEN_W), .DW(DW)) u_unpack (
    .clk(clk), .rst(rst),
    .ld_addr(st == S_CTL), .addr_in(mem_rdata[AW-1:0]),
    .ld_len(frame_go), .len_in(mem_rdata[LEN_W-1:0]),
    .ld_word(st == S_BLD), .word_in(mem_rdata),
    .take(take), .cur_addr(cur_addr), .byte_out(cur_byte),
    .last_byte(last_byte), .lane_end(lane_end)
  );

  tdr_err_latch #(.NF(2)) u_err (
    .clk(clk), .rst(rst), .clr(err_clr), .active(st != S_IDLE),
    .ev_in({retry_lim_in, underrun_in}), .ev_q(err_q)
  );

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      st        <= S_IDLE;
      in_frame  <= 1'b0;
      halt_pend <= 1'b0;
      exh_q     <= 1'b0;
      sof_pend  <= 1'b0;
      nocrc_q   <= 1'b0;
      ctl_q     <= '0;
    end else begin
      if (halt_cmd && st != S_IDLE) halt_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          halt_pend <= 1'b0;
          if (start_cmd) st <= S_ADR;
        end
        S_ADR: st <= S_CTL;
        S_CTL: st <= S_DEC;
        S_DEC: begin
          ctl_q <= mem_rdata;
          if (dec_used) begin
            if (in_frame) begin
              exh_q <= 1'b1;
              st    <= S_WB;
            end else begin
              st <= S_IDLE;
            end
          end else if (dec_halt) begin
            st <= S_IDLE;
          end else begin
            if (!in_frame) begin
              in_frame <= 1'b1;
              nocrc_q  <= mem_rdata[B_NOCRC];
              sof_pend <= 1'b1;
            end
            st <= (mem_rdata[LEN_W-1:0] == '0) ? S_WB : S_BRD;
          end
        end
        S_BRD: st <= S_BLD;
        S_BLD: st <= S_EMIT;
        S_EMIT: begin
          if (out_ready) begin
            sof_pend <= 1'b0;
            if (last_byte)     st <= S_WB;
            else if (lane_end) st <= S_BRD;
          end
        end
        S_WB: begin
          if (exh_q) begin
            exh_q    <= 1'b0;
            in_frame <= 1'b0;
            st       <= S_IDLE;
          end else if (ctl_q[B_LAST]) begin
            in_frame <= 1'b0;
            st       <= halt_pend ? S_IDLE : S_ADR;
          end else begin
            st <= S_ADR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd = (st == S_ADR) || (st == S_CTL) || (st == S_BRD);
    mem_we = (st == S_WB);
    case (st)
      S_CTL, S_WB: mem_addr = ptr + CTL_OFS;
      S_BRD:       mem_addr = {cur_addr[AW-1:LB], {LB{1'b0}}};
      default:     mem_addr = ptr;
    endcase
    mem_wdata         = ctl_q;
    mem_wdata[B_USED] = 1'b1;
    if (exh_q) begin
      mem_wdata[B_EXH] = 1'b1;
    end else if (ctl_q[B_LAST]) begin
      mem_wdata[B_UND] = ctl_q[B_UND] | err_q[0];
      mem_wdata[B_RTY] = ctl_q[B_RTY] | err_q[1];
    end
  end

  assign busy      = (st != S_IDLE);
  assign out_valid = (st == S_EMIT);
  assign out_data  = cur_byte;
  assign out_sof   = out_valid && sof_pend;
  assign out_eof   = out_valid && ctl_q[B_LAST] && last_byte;
  assign out_nocrc = nocrc_q;

  // R3: the memory port never reads and writes in one cycle
  p_rw_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we));
  // R2: a start while enabled and idle raises busy next cycle
  p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_cmd && tx_en) |=> busy);
  // R6: a stalled byte is held unchanged
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && tx_en) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));
  // R7: every write-back hands the descriptor back with used set
  p_wb_used_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata[B_USED]);
  // R13: disabling the transmitter forces idle
  p_off_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !busy);
endmodule

// File: tb/tb_tdr_tx_ring.sv
`timescale 1ns/1ps
module tb_tdr_tx_ring;
  localparam int AW   = 12;
  localparam int BASE = 'h100;
  localparam logic [31:0] F_LAST  = 32'h0000_8000;
  localparam logic [31:0] F_NOCRC = 32'h0001_0000;
  localparam logic [31:0] F_EXH   = 32'h0800_0000;
  localparam logic [31:0] F_UND   = 32'h1000_0000;
  localparam logic [31:0] F_RTY   = 32'h2000_0000;
  localparam logic [31:0] F_WRAP  = 32'h4000_0000;
  localparam logic [31:0] F_USED  = 32'h8000_0000;
  // {stall[15], nocrc[14], offset[13:12], length[11:0]}; expected count = length
  localparam logic [15:0] VEC [6] = '{16'h0001, 16'h7001, 16'h9006,
                                      16'hE009, 16'h0008, 16'hB00D};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, tx_en, start_cmd, halt_cmd, busy, mem_rd, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic underrun_in, retry_lim_in, out_valid, out_ready, out_data_unused;
  logic [7:0] out_data;
  logic out_sof, out_eof, out_nocrc;

  tdr_tx_ring #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .ring_base(AW'(BASE)),
    .start_cmd(start_cmd), .halt_cmd(halt_cmd), .busy(busy),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .underrun_in(underrun_in), .retry_lim_in(retry_lim_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_nocrc(out_nocrc)
  );
  assign out_data_unused = 1'b0;

  logic [31:0] mem [1024];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[AW-1:2]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[AW-1:2]];
  end

  int nchk = 0, nfail = 0;
  int ncap = 0, cyc = 0, stall_err = 0, stall_seen = 0;
  logic rdy = 1'b1, stall_mode = 1'b0, arm = 1'b0, hold_pend = 1'b0;
  logic [7:0] hd;
  logic hs, he;
  logic [AW-1:0] first_rd, last_rd;
  logic [7:0] cap_d [64];
  logic cap_s [64], cap_e [64], cap_n [64];
  assign out_ready = rdy;

  always @(negedge clk) begin
    rdy = stall_mode ? (cyc % 3 != 0) : 1'b1;
    cyc++;
    if (hold_pend && (!out_valid || out_data !== hd || out_sof !== hs || out_eof !== he))
      stall_err++;
    hold_pend = out_valid && !rdy;
    if (hold_pend) stall_seen++;
    hd = out_data; hs = out_sof; he = out_eof;
    if (out_valid && rdy && ncap < 64) begin
      cap_d[ncap] = out_data; cap_s[ncap] = out_sof;
      cap_e[ncap] = out_eof;  cap_n[ncap] = out_nocrc;
      ncap++;
    end
    if (mem_rd) begin
      last_rd = mem_addr;
      if (arm) begin first_rd = mem_addr; arm = 1'b0; end
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13) ^ (a >> 5) ^ 'h5A);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_desc(input int idx, input logic [31:0] a, input logic [31:0] c);
    mem[(BASE >> 2) + 2*idx]     = a;
    mem[(BASE >> 2) + 2*idx + 1] = c;
  endtask

  function automatic logic [31:0] ctl_of(input int idx);
    return mem[(BASE >> 2) + 2*idx + 1];
  endfunction

  task automatic run(input int und_at, input int rty_at, input int hlt_at);
    int k;
    ncap = 0; arm = 1'b1;
    @(negedge clk) start_cmd = 1'b1;
    @(negedge clk) start_cmd = 1'b0;
    chk("R2 busy after start", 32'(busy), 32'd1);
    k = 0;
    while (busy && k < 3000) begin
      underrun_in  = (k == und_at);
      retry_lim_in = (k == rty_at);
      halt_cmd     = (k == hlt_at);
      @(negedge clk);
      k++;
    end
    underrun_in = 1'b0; retry_lim_in = 1'b0; halt_cmd = 1'b0;
    if (k >= 3000) chk("R2 busy drops", 32'd1, 32'd0);
    @(negedge clk);
  endtask

  task automatic check_frame(input int a, input int len, input logic nc,
                             input logic eof_exp, input string etag);
    int nsof, neof, nbad;
    nsof = 0; neof = 0; nbad = 0;
    chk("R3 byte count", 32'(ncap), 32'(len));
    for (int i = 0; i < ncap && i < 64; i++) begin
      chk("R3 byte value", 32'(cap_d[i]), 32'(pat(a + i)));
      nsof += int'(cap_s[i]);
      neof += int'(cap_e[i]);
      if (cap_n[i] !== nc) nbad++;
    end
    chk("R4 sof on first byte", 32'(cap_s[0]), 32'd1);
    chk("R4 sof count", 32'(nsof), 32'd1);
    if (eof_exp) begin
      chk("R4 eof on last byte", 32'(cap_e[len-1]), 32'd1);
      chk("R4 eof count", 32'(neof), 32'd1);
    end else begin
      chk(etag, 32'(neof), 32'd0);
    end
    chk("R5 nocrc sideband", 32'(nbad), 32'd0);
  endtask

  initial begin
    rst = 1'b1; tx_en = 1'b0; start_cmd = 1'b0; halt_cmd = 1'b0;
    underrun_in = 1'b0; retry_lim_in = 1'b0;
    for (int w = 0; w < 1024; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 mem strobes", 32'({mem_rd, mem_we}), 32'd0);
    tx_en = 1'b1;
    @(negedge clk);

    // vector table: single-buffer frames at varied alignment and lengths
    for (int t = 0; t < 6; t++) begin
      logic [15:0] v;
      int a, len;
      logic [31:0] c;
      v = VEC[t];
      len = int'(v[11:0]);
      a = 'h400 + 32*t + int'(v[13:12]);
      c = 32'(len) | F_LAST | (v[14] ? F_NOCRC : 32'd0) | F_WRAP;
      set_desc(0, 32'(a), c);
      stall_mode = v[15];
      run(-1, -1, -1);
      chk("R2 first fetch at base", 32'(first_rd), 32'(BASE));
      check_frame(a, len, v[14], 1'b1, "R4 eof");
      chk("R7 write-back", ctl_of(0), c | F_USED);
      chk("R8 wrap refetch base", 32'(last_rd), 32'(BASE + 4));
    end
    stall_mode = 1'b0;

    // multi-buffer frame, underrun, stop on used descriptor at frame start
    set_desc(0, 32'h600, 32'd3);
    set_desc(1, 32'h612, 32'd2 | F_LAST | F_NOCRC);
    set_desc(2, 32'h620, 32'd2 | F_LAST | F_WRAP | F_USED);
    run(8, -1, -1);
    chk("R4 buf0 byte0", 32'(cap_d[0]), 32'(pat('h600)));
    chk("R4 buf1 byte0", 32'(cap_d[3]), 32'(pat('h612)));
    chk("R4 buf1 byte1", 32'(cap_d[4]), 32'(pat('h613)));
    chk("R4 count", 32'(ncap), 32'd5);
    chk("R4 eof last", 32'(cap_e[4]), 32'd1);
    chk("R4 no early eof", 32'(cap_e[2]), 32'd0);
    chk("R5 nocrc from first desc", 32'({cap_n[0], cap_n[4]}), 32'd0);
    chk("R7 mid-frame write-back", ctl_of(0), 32'd3 | F_USED);
    chk("R11 underrun flag", ctl_of(1), 32'd2 | F_LAST | F_NOCRC | F_USED | F_UND);
    chk("R9 used desc untouched", ctl_of(2), 32'd2 | F_LAST | F_WRAP | F_USED);
    chk("R9 stopped after fetch", 32'(last_rd), 32'(BASE + 20));

    // restart continues at the same descriptor; retry flag; wrap
    set_desc(2, 32'h620, 32'd2 | F_LAST | F_WRAP);
    run(-1, 5, -1);
    chk("R13 position kept", 32'(first_rd), 32'(BASE + 16));
    check_frame('h620, 2, 1'b0, 1'b1, "R4 eof");
    chk("R11 retry flag", ctl_of(2), 32'd2 | F_LAST | F_WRAP | F_USED | F_RTY);
    chk("R8 wrap to base", 32'(last_rd), 32'(BASE + 4));

    // halt lets the current frame finish
    set_desc(0, 32'h700, 32'd4 | F_LAST);
    set_desc(1, 32'h710, 32'd3 | F_LAST);
    run(-1, -1, 3);
    check_frame('h700, 4, 1'b0, 1'b1, "R12 eof");
    chk("R12 frame written back", ctl_of(0), 32'd4 | F_LAST | F_USED);
    chk("R12 next desc untouched", ctl_of(1), 32'd3 | F_LAST);
    chk("R12 no further fetch", 32'(last_rd), 32'h700);
    run(-1, -1, -1);
    chk("R13 resumes after halt", 32'(first_rd), 32'(BASE + 8));
    check_frame('h710, 3, 1'b0, 1'b1, "R4 eof");

    // disable rewinds to base; used descriptor mid-frame
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
    set_desc(0, 32'h740, 32'd2);
    set_desc(1, 32'h750, 32'd5 | F_LAST | F_USED);
    run(-1, -1, -1);
    chk("R13 rewound to base", 32'(first_rd), 32'(BASE));
    check_frame('h740, 2, 1'b0, 1'b0, "R10 no eof");
    chk("R10 exhausted flag", ctl_of(1), 32'd5 | F_LAST | F_USED | F_EXH);
    chk("R10 first buffer released", ctl_of(0), 32'd2 | F_USED);
    chk("R10 idle", 32'(busy), 32'd0);

    chk("R6 stall hold", 32'(stall_err), 32'd0);
    chk("R6 stalls exercised", 32'(stall_seen > 0), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule